// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block chooses and runs the low-power state a processor enters when it executes a sleep request. It reads three control bits: standby select, clock-stop enable and output-port enable. It also reads a 32-bit module-stop mask. From these it picks one of three states: plain sleep, all-module clock stop, or software standby. It then drives the clock enables for the CPU, the modules, the bus, the 8-bit timer and the watchdog. It also drives the oscillator enable and the behaviour of the bus outputs. An active-low standby pin overrides everything and forces hardware standby.

Wake-up goes through a qualification stage. NMI always wakes the block. The IRQ, timer and watchdog sources are blocked by a global disable or by a mask of everything except NMI. Each of them is also blocked individually when it is routed to the DMA transfer engine. A wake from the sleep or clock-stop states returns at once to the run state. A wake from software standby first turns the oscillator back on, then waits a programmable number of cycles. Each return to run raises a one-cycle resume-via-exception request.

The mode encoding is: 0 run, 1 sleep, 2 drain (waiting for the bus cycle to end), 3 clock stop, 4 software standby, 5 oscillator settle, 6 hardware standby. All outputs decode from registered state, so every change shows up in the cycle after the edge that caused it.

Top module: `lpm_sequencer`

## Requirements
- R1: During and after reset, mode is 0. Every clock enable and the oscillator enable are 1. busHiZ, busHold, resumeExc and entryErr are 0.
- R2: A sleep request in run mode with standbySel=0 enters mode 1 when the clock-stop conditions are not met. Mode 1 drops only cpuClkEn.
- R3: A sleep request in run mode with standbySel=0, clkStopEn=1 and moduleStopMask all ones enters mode 2. Bits 27:24 of the mask may take any value; every other bit must be 1.
- R4: The block leaves mode 2 for mode 3 only on the edge where busCycleDone is 1. It stays in mode 2 without that strobe.
- R5: In mode 3, cpuClkEn, moduleClkEn and busClkEn are 0, and wdtClkEn and oscEn are 1. timerClkEn is 1 exactly when at least one mask bit in 27:24 is 0.
- R6: A qualified wake in modes 1, 2 or 3 returns to mode 0. resumeExc is 1 for exactly that first cycle back in mode 0.
- R7: NMI always qualifies as a wake. The other sources do not qualify while intDisable=1 or intMaskAll=1. A source also does not qualify when its dtcRoute bit is 1. dtcRoute bits 11:0 map to irq[11:0], bit 12 to timerIrq and bit 13 to wdtIrq.
- R8: A sleep request in run mode with standbySel=1 and wdtWatchdogMode=0 enters mode 4. In mode 4 all clock enables and oscEn are 0.
- R9: In modes 4 and 5, portOutEn=0 gives busHiZ=1 and busHold=0, and portOutEn=1 gives busHiZ=0 and busHold=1.
- R10: A standby request made while wdtWatchdogMode=1 leaves the block in mode 0 and sets entryErr. The next sleep request that is accepted clears entryErr.
- R11: A qualified wake in mode 4 enters mode 5, in which oscEn=1 and all clock enables are 0. The block stays in mode 5 for settleCount+1 cycles, then returns to mode 0 with resumeExc=1.
- R12: standbyPinN=0 enters mode 6 on the next edge from any state. Mode 6 drops all clocks and the oscillator and sets busHiZ=1. The block stays in mode 6 after the pin returns high, until reset.
- R13: Sleep requests are ignored in every mode other than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, top-priority wake |
| sleepReq | input | 1 | Sleep instruction strobe |
| standbySel | input | 1 | 1 selects software standby |
| clkStopEn | input | 1 | Allows all-module clock stop |
| portOutEn | input | 1 | Bus output behaviour in standby: 1 hold, 0 float |
| moduleStopMask | input | 32 | Module-stop mask |
| busCycleDone | input | 1 | Current bus cycle has finished |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | 12 | External interrupt lines |
| timerIrq | input | 1 | 8-bit timer interrupt |
| wdtIrq | input | 1 | Watchdog interval interrupt |
| intDisable | input | 1 | Global interrupt disable |
| intMaskAll | input | 1 | All interrupts except NMI masked |
| dtcRoute | input | 14 | Per-source routing to the DMA transfer engine |
| standbyPinN | input | 1 | Active-low hardware standby pin |
| wdtWatchdogMode | input | 1 | Watchdog is running in watchdog mode |
| settleCount | input | SETTLE_W | Oscillator settle cycles minus one |
| cpuClkEn | output | 1 | CPU clock enable |
| moduleClkEn | output | 1 | Peripheral module clock enable |
| busClkEn | output | 1 | Bus controller and I/O port clock enable |
| timerClkEn | output | 1 | 8-bit timer clock enable |
| wdtClkEn | output | 1 | Watchdog clock enable |
| oscEn | output | 1 | Oscillator enable |
| busHiZ | output | 1 | Float address bus and bus control outputs |
| busHold | output | 1 | Hold last driven bus output values |
| mode | output | 3 | Current mode, encoded as in the description |
| resumeExc | output | 1 | Resume-via-exception request |
| entryErr | output | 1 | Standby entry refused |

## Verification
The bench builds the block with SETTLE_W=4, which keeps the widest settle window at 16 cycles. It runs settleCount at 0 and at 3, so both the single-cycle settle and a multi-cycle countdown are timed exactly. IRQ_N stays at 12, and with the 14-bit routing vector this lets the bench set the routing of one specific IRQ and show that only that source is blocked. The module-stop masks used put the 8-bit timer field once at a mixed value and once at all ones, which covers both outcomes of timerClkEn in clock-stop.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    MODE_RUN     = 3'd0,
    MODE_SLEEP   = 3'd1,
    MODE_DRAIN   = 3'd2,
    MODE_CLKSTOP = 3'd3,
    MODE_SWSTBY  = 3'd4,
    MODE_SETTLE  = 3'd5,
    MODE_HWSTBY  = 3'd6
  } lpm_mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadSettle;
    logic setErr;
    logic clrErr;
  } lpm_strobe_t;

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReq,
  input  logic        standbySel,
  input  logic        clkStopEn,
  input  logic        wdtWatchdogMode,
  input  logic        busCycleDone,
  input  logic        standbyPinN,
  input  logic        wakeOk,
  input  logic        maskOk,
  input  logic        settleDone,
  output lpm_mode_e   mode,
  output lpm_strobe_t strobe,
  output logic        resumeExc
);

  lpm_mode_e modeNext;
  logic      resumeNext;
  logic      acceptReq;
  logic      refuseReq;

  always_comb begin
    refuseReq = (mode == MODE_RUN) && sleepReq && standbySel && wdtWatchdogMode;
    acceptReq = (mode == MODE_RUN) && sleepReq && !refuseReq;
  end

  always_comb begin
    modeNext   = mode;
    resumeNext = 1'b0;
    strobe     = '0;
    if (!standbyPinN) begin
      modeNext = MODE_HWSTBY;
    end else begin
      unique case (mode)
        MODE_RUN: begin
          strobe.setErr = refuseReq;
          strobe.clrErr = acceptReq;
          if (acceptReq) begin
            if (standbySel)              modeNext = MODE_SWSTBY;
            else if (clkStopEn && maskOk) modeNext = MODE_DRAIN;
            else                         modeNext = MODE_SLEEP;
          end
        end
        MODE_SLEEP, MODE_CLKSTOP: begin
          if (wakeOk) begin
            modeNext   = MODE_RUN;
            resumeNext = 1'b1;
          end
        end
        MODE_DRAIN: begin
          if (wakeOk) begin
            modeNext   = MODE_RUN;
            resumeNext = 1'b1;
          end else if (busCycleDone) begin
            modeNext = MODE_CLKSTOP;
          end
        end
        MODE_SWSTBY: begin
          if (wakeOk) begin
            modeNext          = MODE_SETTLE;
            strobe.loadSettle = 1'b1;
          end
        end
        MODE_SETTLE: begin
          if (settleDone) begin
            modeNext   = MODE_RUN;
            resumeNext = 1'b1;
          end
        end
        MODE_HWSTBY: modeNext = MODE_HWSTBY;
        default:     modeNext = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_RUN;
      resumeExc <= 1'b0;
    end else begin
      mode      <= modeNext;
      resumeExc <= resumeNext;
    end
  end

endmodule

// File: rtl/lpm_dpath.sv
module lpm_dpath
  import lpm_pkg::*;
#(
  parameter int IRQ_N    = 12,
  parameter int MASK_W   = 32,
  parameter int TMR_LSB  = 24,
  parameter int TMR_MSB  = 27,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  lpm_mode_e           mode,
  input  lpm_strobe_t         strobe,
  input  logic [MASK_W-1:0]   moduleStopMask,
  input  logic                nmi,
  input  logic [IRQ_N-1:0]    irq,
  input  logic                timerIrq,
  input  logic                wdtIrq,
  input  logic                intDisable,
  input  logic                intMaskAll,
  input  logic [IRQ_N+1:0]    dtcRoute,
  input  logic                portOutEn,
  input  logic [SETTLE_W-1:0] settleCount,
  output logic                wakeOk,
  output logic                maskOk,
  output logic                settleDone,
  output logic                cpuClkEn,
  output logic                moduleClkEn,
  output logic                busClkEn,
  output logic                timerClkEn,
  output logic                wdtClkEn,
  output logic                oscEn,
  output logic                busHiZ,
  output logic                busHold,
  output logic                entryErr
);

  localparam int SRC_N = IRQ_N + 2;
  localparam int TMR_W = TMR_MSB - TMR_LSB + 1;
  localparam logic [MASK_W-1:0] TMR_FIELD =
    {{(MASK_W-TMR_W){1'b0}}, {TMR_W{1'b1}}} << TMR_LSB;

  // wake qualification, one lane per maskable source
  logic [SRC_N-1:0] srcVec;
  logic [SRC_N-1:0] cpuBound;
  assign srcVec = {wdtIrq, timerIrq, irq};

  for (genvar i = 0; i < SRC_N; i++) begin : g_route
    assign cpuBound[i] = srcVec[i] & ~dtcRoute[i];
  end

  assign wakeOk = nmi | (~intDisable & ~intMaskAll & (|cpuBound));

  // module-stop mask decode
  logic timerStopped;
  assign maskOk       = &(moduleStopMask | TMR_FIELD);
  assign timerStopped = &moduleStopMask[TMR_MSB:TMR_LSB];

  // oscillator settle counter
  logic [SETTLE_W-1:0] settleCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strobe.loadSettle) begin
      settleCnt <= settleCount;
    end else if (mode == MODE_SETTLE && settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end
  assign settleDone = (mode == MODE_SETTLE) && (settleCnt == '0);

  // refused-entry flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              entryErr <= 1'b0;
    else if (strobe.setErr) entryErr <= 1'b1;
    else if (strobe.clrErr) entryErr <= 1'b0;
  end

  // output decode from mode
  always_comb begin
    cpuClkEn    = 1'b0;
    moduleClkEn = 1'b0;
    busClkEn    = 1'b0;
    timerClkEn  = 1'b0;
    wdtClkEn    = 1'b0;
    oscEn       = 1'b0;
    busHiZ      = 1'b0;
    busHold     = 1'b0;
    unique case (mode)
      MODE_RUN: begin
        cpuClkEn    = 1'b1;
        moduleClkEn = 1'b1;
        busClkEn    = 1'b1;
        timerClkEn  = 1'b1;
        wdtClkEn    = 1'b1;
        oscEn       = 1'b1;
      end
      MODE_SLEEP, MODE_DRAIN: begin
        moduleClkEn = 1'b1;
        busClkEn    = 1'b1;
        timerClkEn  = 1'b1;
        wdtClkEn    = 1'b1;
        oscEn       = 1'b1;
      end
      MODE_CLKSTOP: begin
        timerClkEn = ~timerStopped;
        wdtClkEn   = 1'b1;
        oscEn      = 1'b1;
      end
      MODE_SWSTBY: begin
        busHiZ  = ~portOutEn;
        busHold = portOutEn;
      end
      MODE_SETTLE: begin
        oscEn   = 1'b1;
        busHiZ  = ~portOutEn;
        busHold = portOutEn;
      end
      MODE_HWSTBY: busHiZ = 1'b1;
      default: begin
        cpuClkEn = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int IRQ_N    = 12,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sleepReq,
  input  logic                standbySel,
  input  logic                clkStopEn,
  input  logic                portOutEn,
  input  logic [31:0]         moduleStopMask,
  input  logic                busCycleDone,
  input  logic                nmi,
  input  logic [IRQ_N-1:0]    irq,
  input  logic                timerIrq,
  input  logic                wdtIrq,
  input  logic                intDisable,
  input  logic                intMaskAll,
  input  logic [IRQ_N+1:0]    dtcRoute,
  input  logic                standbyPinN,
  input  logic                wdtWatchdogMode,
  input  logic [SETTLE_W-1:0] settleCount,
  output logic                cpuClkEn,
  output logic                moduleClkEn,
  output logic                busClkEn,
  output logic                timerClkEn,
  output logic                wdtClkEn,
  output logic                oscEn,
  output logic                busHiZ,
  output logic                busHold,
  output logic [2:0]          mode,
  output logic                resumeExc,
  output logic                entryErr
);

  lpm_mode_e   modeQ;
  lpm_strobe_t strobe;
  logic        wakeOk;
  logic        maskOk;
  logic        settleDone;

  lpm_ctrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .sleepReq        (sleepReq),
    .standbySel      (standbySel),
    .clkStopEn       (clkStopEn),
    .wdtWatchdogMode (wdtWatchdogMode),
    .busCycleDone    (busCycleDone),
    .standbyPinN     (standbyPinN),
    .wakeOk          (wakeOk),
    .maskOk          (maskOk),
    .settleDone      (settleDone),
    .mode            (modeQ),
    .strobe          (strobe),
    .resumeExc       (resumeExc)
  );

  lpm_dpath #(
    .IRQ_N    (IRQ_N),
    .MASK_W   (32),
    .TMR_LSB  (24),
    .TMR_MSB  (27),
    .SETTLE_W (SETTLE_W)
  ) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .mode           (modeQ),
    .strobe         (strobe),
    .moduleStopMask (moduleStopMask),
    .nmi            (nmi),
    .irq            (irq),
    .timerIrq       (timerIrq),
    .wdtIrq         (wdtIrq),
    .intDisable     (intDisable),
    .intMaskAll     (intMaskAll),
    .dtcRoute       (dtcRoute),
    .portOutEn      (portOutEn),
    .settleCount    (settleCount),
    .wakeOk         (wakeOk),
    .maskOk         (maskOk),
    .settleDone     (settleDone),
    .cpuClkEn       (cpuClkEn),
    .moduleClkEn    (moduleClkEn),
    .busClkEn       (busClkEn),
    .timerClkEn     (timerClkEn),
    .wdtClkEn       (wdtClkEn),
    .oscEn          (oscEn),
    .busHiZ         (busHiZ),
    .busHold        (busHold),
    .entryErr       (entryErr)
  );

  assign mode = modeQ;

endmodule

// File: rtl/lpm_checker.sv
module lpm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sleepReq,
  input logic       standbySel,
  input logic       wdtWatchdogMode,
  input logic       standbyPinN,
  input logic       busCycleDone,
  input logic       portOutEn,
  input logic [2:0] mode,
  input logic       resumeExc,
  input logic       entryErr,
  input logic       cpuClkEn,
  input logic       oscEn,
  input logic       busHiZ,
  input logic       busHold
);

  a_r12_pin_forces_hw: assert property (@(posedge clk) disable iff (!rstN)
    !standbyPinN |=> mode == 3'd6);

  a_r12_hw_sticky: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd6 |=> mode == 3'd6);

  a_r8_standby_all_off: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd4 |-> !oscEn && !cpuClkEn);

  a_r11_settle_osc_only: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd5 |-> oscEn && !cpuClkEn);

  a_r6_resume_after_exit: assert property (@(posedge clk) disable iff (!rstN)
    resumeExc |-> mode == 3'd0 && $past(mode) != 3'd0);

  a_r4_stop_after_done: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd3 && $past(mode) != 3'd3) |-> $past(busCycleDone));

  a_r10_refuse_stays: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd0 && sleepReq && standbySel && wdtWatchdogMode && standbyPinN)
      |=> mode == 3'd0 && entryErr);

  a_r9_bus_choice: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd4 || mode == 3'd5) |-> (busHold == portOutEn) && (busHiZ == !portOutEn));

endmodule

bind lpm_sequencer lpm_checker u_lpm_checker (
  .clk             (clk),
  .rstN            (rstN),
  .sleepReq        (sleepReq),
  .standbySel      (standbySel),
  .wdtWatchdogMode (wdtWatchdogMode),
  .standbyPinN     (standbyPinN),
  .busCycleDone    (busCycleDone),
  .portOutEn       (portOutEn),
  .mode            (mode),
  .resumeExc       (resumeExc),
  .entryErr        (entryErr),
  .cpuClkEn        (cpuClkEn),
  .oscEn           (oscEn),
  .busHiZ          (busHiZ),
  .busHold         (busHold)
);

// File: tb/lpm_sequencer_bench.sv
`timescale 1ns/1ps
module lpm_sequencer_bench;

  localparam int IRQ_N    = 12;
  localparam int SETTLE_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq, standbySel, clkStopEn, portOutEn, busCycleDone;
  logic [31:0] moduleStopMask;
  logic nmi, timerIrq, wdtIrq, intDisable, intMaskAll, standbyPinN, wdtWatchdogMode;
  logic [IRQ_N-1:0] irq;
  logic [IRQ_N+1:0] dtcRoute;
  logic [SETTLE_W-1:0] settleCount;
  logic cpuClkEn, moduleClkEn, busClkEn, timerClkEn, wdtClkEn, oscEn, busHiZ, busHold;
  logic [2:0] mode;
  logic resumeExc, entryErr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lpm_sequencer #(.IRQ_N(IRQ_N), .SETTLE_W(SETTLE_W)) u_lpm_sequencer (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .standbySel(standbySel),
    .clkStopEn(clkStopEn), .portOutEn(portOutEn), .moduleStopMask(moduleStopMask),
    .busCycleDone(busCycleDone), .nmi(nmi), .irq(irq), .timerIrq(timerIrq),
    .wdtIrq(wdtIrq), .intDisable(intDisable), .intMaskAll(intMaskAll),
    .dtcRoute(dtcRoute), .standbyPinN(standbyPinN), .wdtWatchdogMode(wdtWatchdogMode),
    .settleCount(settleCount), .cpuClkEn(cpuClkEn), .moduleClkEn(moduleClkEn),
    .busClkEn(busClkEn), .timerClkEn(timerClkEn), .wdtClkEn(wdtClkEn), .oscEn(oscEn),
    .busHiZ(busHiZ), .busHold(busHold), .mode(mode), .resumeExc(resumeExc),
    .entryErr(entryErr)
  );

  // {cpu, module, bus, timer, wdt, osc, hiZ, hold}
  function automatic logic [7:0] outv();
    return {cpuClkEn, moduleClkEn, busClkEn, timerClkEn, wdtClkEn, oscEn, busHiZ, busHold};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setIdle();
    sleepReq = 0; standbySel = 0; clkStopEn = 0; portOutEn = 0; busCycleDone = 0;
    moduleStopMask = '0; nmi = 0; irq = '0; timerIrq = 0; wdtIrq = 0;
    intDisable = 0; intMaskAll = 0; dtcRoute = '0; standbyPinN = 1;
    wdtWatchdogMode = 0; settleCount = '0;
  endtask

  task automatic doReset();
    setIdle();
    rstN = 0;
    tick(); tick();
    rstN = 1;
    tick();
  endtask

  task automatic pulseSleep();
    sleepReq = 1;
    tick();
    sleepReq = 0;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 mode", mode, 0);
    chk("R1 outputs", outv(), 8'b1111_1100);
    chk("R1 flags", {resumeExc, entryErr}, 0);
  endtask

  task automatic t_sleep();
    doReset();
    clkStopEn = 1; moduleStopMask = 32'hFFFF_FFFE;
    pulseSleep();
    chk("R2 mode", mode, 1);
    chk("R2 outputs", outv(), 8'b0111_1100);
    standbySel = 1; pulseSleep(); standbySel = 0;
    chk("R13 ignored", mode, 1);
    irq[3] = 1; tick(); irq[3] = 0;
    chk("R6 wake mode", mode, 0);
    chk("R6 resume", resumeExc, 1);
    tick();
    chk("R6 resume one cycle", resumeExc, 0);
  endtask

  task automatic t_clkstop_timer_on();
    doReset();
    clkStopEn = 1; moduleStopMask = 32'hF5FF_FFFF;
    pulseSleep();
    chk("R3 drain", mode, 2);
    tick();
    chk("R4 held", mode, 2);
    busCycleDone = 1; tick(); busCycleDone = 0;
    chk("R4 stop", mode, 3);
    chk("R5 outputs timer on", outv(), 8'b0001_1100);
    irq[0] = 1; intDisable = 1; tick();
    chk("R7 disabled", mode, 3);
    intDisable = 0; intMaskAll = 1; tick();
    chk("R7 masked", mode, 3);
    intMaskAll = 0; dtcRoute[0] = 1; tick();
    chk("R7 routed", mode, 3);
    irq[0] = 0; dtcRoute = '0; intDisable = 1; nmi = 1; tick(); nmi = 0; intDisable = 0;
    chk("R7 nmi wakes", mode, 0);
    chk("R6 resume", resumeExc, 1);
  endtask

  task automatic t_clkstop_timer_off();
    doReset();
    clkStopEn = 1; moduleStopMask = 32'hFFFF_FFFF; busCycleDone = 1;
    pulseSleep();
    tick(); busCycleDone = 0;
    chk("R3 mode", mode, 3);
    chk("R5 timer off", outv(), 8'b0000_1100);
    dtcRoute[12] = 1; wdtIrq = 1; tick(); wdtIrq = 0;
    chk("R6 wdt wake", {mode, resumeExc}, {3'd0, 1'b1});
  endtask

  task automatic t_standby_float();
    doReset();
    standbySel = 1; portOutEn = 0; settleCount = 4'd3;
    pulseSleep();
    chk("R8 mode", mode, 4);
    chk("R9 float", outv(), 8'b0000_0010);
    irq[11] = 1; tick(); irq[11] = 0;
    chk("R11 settle", mode, 5);
    chk("R11 outputs", outv(), 8'b0000_0110);
    tick(); tick(); tick();
    chk("R11 still settling", {mode, resumeExc}, {3'd5, 1'b0});
    tick();
    chk("R11 done", {mode, resumeExc}, {3'd0, 1'b1});
  endtask

  task automatic t_standby_hold();
    doReset();
    standbySel = 1; portOutEn = 1; settleCount = 4'd0;
    pulseSleep();
    chk("R9 hold", outv(), 8'b0000_0001);
    nmi = 1; tick(); nmi = 0;
    chk("R11 settle", mode, 5);
    tick();
    chk("R11 zero count", {mode, resumeExc}, {3'd0, 1'b1});
  endtask

  task automatic t_refuse();
    doReset();
    standbySel = 1; wdtWatchdogMode = 1;
    pulseSleep();
    chk("R10 refused", {mode, entryErr}, {3'd0, 1'b1});
    wdtWatchdogMode = 0;
    pulseSleep();
    chk("R10 accepted clears", {mode, entryErr}, {3'd4, 1'b0});
  endtask

  task automatic t_hwstby();
    doReset();
    pulseSleep();
    chk("R2 sleep", mode, 1);
    standbyPinN = 0; tick();
    chk("R12 enter", mode, 6);
    chk("R12 outputs", outv(), 8'b0000_0010);
    standbyPinN = 1; irq[1] = 1; tick(); irq[1] = 0;
    chk("R12 sticky", mode, 6);
    doReset();
    chk("R1 exit via reset", mode, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    setIdle();
    t_reset();
    t_sleep();
    t_clkstop_timer_on();
    t_clkstop_timer_off();
    t_standby_float();
    t_standby_hold();
    t_refuse();
    t_hwstby();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule